// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block follows a falling and recovering supply through a series of stages. Three comparators report whether the supply is above the warning level, the minimum operating level and the backup switch-over level. The block synchronizes each comparator output and filters it for stability. It then runs a five-state sequencer with the states NORMAL, WARN, RESET, BACKUP and POR_DELAY.

In the warning stage the processor keeps running and receives a one-shot interrupt request that carries the vector 0x2B. Below the minimum level the processor is held in reset. The memory chip enables and the read/write strobe are forced inactive high. Below the backup level the backup cell is selected as the power source. When the supply returns, reset is held for a counted power-on delay before execution resumes. An external active-high reset request is merged into the reset output.

Top module: `pwr_fail_seq`

## Requirements
- R1: In the WARN stage with `warn_en_i` high and the request armed, `irq_o` pulses high for exactly one cycle. `irq_vec_o` reads 8'h2B while `irq_o` is high and 8'h00 otherwise.
- R2: In the WARN stage `cpu_rst_o` stays low, apart from `ext_rst_i`. `ce_n_o` and `rw_n_o` follow `ce_n_i` and `rw_n_i`.
- R3: When the filtered minimum-level comparator reads low, the sequencer enters RESET and `cpu_rst_o` is high. Reset stays high until that comparator reads high again.
- R4: In RESET, BACKUP and POR_DELAY, every bit of `ce_n_o` is 1 and `rw_n_o` is 1. In NORMAL and WARN both outputs pass their inputs through unchanged.
- R5: `bkp_sel_o` is high exactly while the sequencer is in BACKUP. BACKUP is entered whenever the filtered backup-level comparator reads low, and this condition has priority over all others.
- R6: The sequencer moves from RESET or BACKUP into POR_DELAY once the minimum and backup comparators both read high. It stays in POR_DELAY for exactly POR_CYCLES (21504) cycles with `cpu_rst_o` high. It then goes to NORMAL if the warning comparator is high, otherwise to WARN.
- R7: Each comparator input passes through SYNC_STAGES (2) flops. A change is accepted only after the synchronized value has differed from the accepted value for STABLE_CYCLES (4) consecutive cycles. Shorter glitches have no effect on any output.
- R8: A warning request fires at most once per excursion. It re-arms only after the sequencer has been in NORMAL, that is with the supply back above the warning level.
- R9: `cpu_rst_o` is the OR of the stage-derived reset and `ext_rst_i`, and it responds to `ext_rst_i` in the same cycle.
- R10: After `rst_ni` the sequencer is in BACKUP with every comparator taken as low. `cpu_rst_o` and `bkp_sel_o` are high and `irq_o` is low.
- R11: With `warn_en_i` low, the WARN stage raises no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| above_warn_i | input | 1 | Comparator: supply above warning level |
| above_min_i | input | 1 | Comparator: supply above minimum operating level |
| above_bkp_i | input | 1 | Comparator: supply above backup switch-over level |
| warn_en_i | input | 1 | Warning interrupt enable |
| ext_rst_i | input | 1 | External active-high reset request |
| ce_n_i | input | NUM_CE | Decoded chip enables from the memory decoder (active low) |
| rw_n_i | input | 1 | Read/write strobe from the processor |
| irq_o | output | 1 | Warning interrupt request, one-cycle pulse |
| irq_vec_o | output | 8 | Interrupt vector, 8'h2B with the request |
| cpu_rst_o | output | 1 | Processor reset |
| ce_n_o | output | NUM_CE | Gated chip enables |
| rw_n_o | output | 1 | Gated read/write strobe |
| bkp_sel_o | output | 1 | Select backup cell as power source |

## Verification
A comparator edge driven between clock edges reaches the accepted value after SYNC_STAGES+STABLE_CYCLES (6) edges. The stage changes one edge later, so `cpu_rst_o`, `bkp_sel_o`, `ce_n_o` and `rw_n_o` move on the seventh edge. `irq_o` follows on the eighth edge. `ext_rst_i`, `ce_n_i` and `rw_n_i` act on the outputs in the same cycle, and POR_DELAY adds exactly POR_CYCLES edges. The bench runs a behavioural model that is updated at each rising edge and compares every output at the falling edge after it. Directed checks count samples between a stimulus and the expected change, using those same latencies.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_WARN   = 3'd1,
    ST_RESET  = 3'd2,
    ST_BACKUP = 3'd3,
    ST_POR    = 3'd4
  } pfs_state_e;

  localparam int CMP_WARN = 0;
  localparam int CMP_MIN  = 1;
  localparam int CMP_BKP  = 2;
  localparam int NUM_CMP  = 3;
endpackage

// File: rtl/pfs_deglitch.sv
module pfs_deglitch #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int RW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [RW-1:0]          run_q;
  logic                   filt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (synced != filt_q) begin
        if (run_q == RUN_LAST) begin
          filt_q <= synced;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (filt_q == $past(synced))); // R7

  AST_FILT_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST); // R7
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
  parameter int POR_CYCLES = 21504
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_LAST);

  AST_POR_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R6

  AST_POR_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
  import pfs_pkg::*;
#(
  parameter int              NUM_CE        = 4,
  parameter int              SYNC_STAGES   = 2,
  parameter int              STABLE_CYCLES = 4,
  parameter int              POR_CYCLES    = 21504,
  parameter int              VEC_W         = 8,
  parameter logic [VEC_W-1:0] WARN_VEC     = VEC_W'(8'h2B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              above_warn_i,
  input  logic              above_min_i,
  input  logic              above_bkp_i,
  input  logic              warn_en_i,
  input  logic              ext_rst_i,
  input  logic [NUM_CE-1:0] ce_n_i,
  input  logic              rw_n_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              cpu_rst_o,
  output logic [NUM_CE-1:0] ce_n_o,
  output logic              rw_n_o,
  output logic              bkp_sel_o
);
  logic [NUM_CMP-1:0] cmp_raw;
  logic [NUM_CMP-1:0] cmp_ok;

  assign cmp_raw[CMP_WARN] = above_warn_i;
  assign cmp_raw[CMP_MIN]  = above_min_i;
  assign cmp_raw[CMP_BKP]  = above_bkp_i;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    pfs_deglitch #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
    ) i_deglitch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (cmp_raw[g]),
      .filt_o(cmp_ok[g])
    );
  end

  pfs_state_e state_q, state_d;
  logic       por_done;
  logic       armed_q;
  logic       irq_q;
  logic       stage_rst;

  pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) i_por_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_POR),
    .done_o(por_done)
  );

  // backup level wins over minimum level, which wins over stage flow
  always_comb begin
    state_d = state_q;
    if (!cmp_ok[CMP_BKP]) begin
      state_d = ST_BACKUP;
    end else if (!cmp_ok[CMP_MIN]) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_BACKUP, ST_RESET: state_d = ST_POR;
        ST_POR:    if (por_done) state_d = cmp_ok[CMP_WARN] ? ST_NORMAL : ST_WARN;
        ST_NORMAL: if (!cmp_ok[CMP_WARN]) state_d = ST_WARN;
        ST_WARN:   if (cmp_ok[CMP_WARN])  state_d = ST_NORMAL;
        default:   state_d = ST_BACKUP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BACKUP;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_WARN) && armed_q && warn_en_i;
      if ((state_q == ST_WARN) && armed_q && warn_en_i) armed_q <= 1'b0;
      else if (state_q == ST_NORMAL)                    armed_q <= 1'b1;
    end
  end

  assign stage_rst = (state_q == ST_RESET) || (state_q == ST_BACKUP) || (state_q == ST_POR);

  assign cpu_rst_o = stage_rst | ext_rst_i;
  assign ce_n_o    = stage_rst ? {NUM_CE{1'b1}} : ce_n_i;
  assign rw_n_o    = stage_rst | rw_n_i;
  assign bkp_sel_o = (state_q == ST_BACKUP);
  assign irq_o     = irq_q;
  assign irq_vec_o = irq_q ? WARN_VEC : '0;

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8

  AST_IRQ_FROM_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(state_q) == ST_WARN) && $past(warn_en_i)); // R1

  AST_WARN_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WARN) && !ext_rst_i) |-> !cpu_rst_o); // R2

  AST_BUS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkp_sel_o |-> ((&ce_n_o) && rw_n_o && cpu_rst_o)); // R4

  AST_POR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_POR) |-> ($past(state_q) == ST_RESET || $past(state_q) == ST_BACKUP)); // R6

  AST_BKP_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_ok[CMP_BKP] |=> bkp_sel_o); // R5

  AST_MIN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_ok[CMP_MIN] |=> cpu_rst_o); // R3
endmodule

// File: tb/test_pwr_fail_seq.sv
module test_pwr_fail_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CE     = 4;
  localparam int SYNC_N     = 2;
  localparam int STABLE_N   = 4;
  localparam int POR_N      = 21504;
  localparam int LAT        = SYNC_N + STABLE_N;
  localparam int WDOG       = 150000;

  localparam int M_NORMAL = 0, M_WARN = 1, M_RESET = 2, M_BACKUP = 3, M_POR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn_in = 1'b0, min_in = 1'b0, bkp_in = 1'b0;
  logic warn_en = 1'b1, ext_rst = 1'b0, rw_n_in = 1'b1;
  logic [NUM_CE-1:0] ce_n_in = '1;
  logic irq, cpu_rst, rw_n_out, bkp_sel;
  logic [7:0] vec;
  logic [NUM_CE-1:0] ce_n_out;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fail_seq #(
    .NUM_CE(NUM_CE), .SYNC_STAGES(SYNC_N), .STABLE_CYCLES(STABLE_N), .POR_CYCLES(POR_N)
  ) i_pwr_fail_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .above_warn_i(warn_in), .above_min_i(min_in), .above_bkp_i(bkp_in),
    .warn_en_i(warn_en), .ext_rst_i(ext_rst), .ce_n_i(ce_n_in), .rw_n_i(rw_n_in),
    .irq_o(irq), .irq_vec_o(vec), .cpu_rst_o(cpu_rst), .ce_n_o(ce_n_out),
    .rw_n_o(rw_n_out), .bkp_sel_o(bkp_sel)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [2:0] hist [$];
  int  run [3];
  bit  acc [3];
  int  m_st, m_por;
  bit  m_armed, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{3'b000, 3'b000};
      for (int i = 0; i < 3; i++) begin run[i] = 0; acc[i] = 0; end
      m_st = M_BACKUP; m_por = 0; m_armed = 1; m_irq = 0;
    end else begin
      logic [2:0] seen;
      int nxt;
      bit fire;
      seen = hist.pop_front();
      hist.push_back({bkp_in, min_in, warn_in});
      fire = (m_st == M_WARN) && m_armed && warn_en;
      nxt = m_st;
      if (!acc[2]) nxt = M_BACKUP;
      else if (!acc[1]) nxt = M_RESET;
      else if (m_st == M_BACKUP || m_st == M_RESET) nxt = M_POR;
      else if (m_st == M_POR) nxt = (m_por == POR_N - 1) ? (acc[0] ? M_NORMAL : M_WARN) : M_POR;
      else if (m_st == M_NORMAL && !acc[0]) nxt = M_WARN;
      else if (m_st == M_WARN && acc[0]) nxt = M_NORMAL;
      m_por = (m_st == M_POR && nxt == M_POR) ? m_por + 1 : 0;
      if (fire) m_armed = 0;
      else if (m_st == M_NORMAL) m_armed = 1;
      m_irq = fire;
      m_st = nxt;
      for (int i = 0; i < 3; i++) begin
        if (seen[i] != acc[i]) begin
          if (run[i] == STABLE_N - 1) begin acc[i] = seen[i]; run[i] = 0; end
          else run[i]++;
        end else run[i] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit forced;
      forced = (m_st == M_RESET || m_st == M_BACKUP || m_st == M_POR);
      check("R3/R6/R9 cpu_rst", cpu_rst, forced | ext_rst);
      check("R4 ce_n", ce_n_out, forced ? {NUM_CE{1'b1}} : ce_n_in);
      check("R4 rw_n", rw_n_out, forced | rw_n_in);
      check("R5 bkp_sel", bkp_sel, m_st == M_BACKUP);
      check("R1/R8/R11 irq", irq, m_irq);
      check("R1 vec", vec, m_irq ? 8'h2B : 8'h00);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(ref logic sig, input int limit, output int c);
    c = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (!sig) return;
      c++;
    end
  endtask

  task automatic count_low(ref logic sig, input int limit, output int c);
    c = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (sig) return;
      c++;
    end
  endtask

  task automatic count_irq(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (irq) c++; end
  endtask

  initial begin
    int c;
    tick(3);
    // R10 reset state
    check("R10 cpu_rst in reset", cpu_rst, 1);
    check("R10 bkp_sel in reset", bkp_sel, 1);
    check("R10 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(2);
    check("R10 bkp_sel after reset", bkp_sel, 1);

    // power-up: backup and minimum return
    warn_in = 1; min_in = 1; bkp_in = 1;
    fork
      begin count_high(bkp_sel, 100, c); check("R5 backup release latency", c, LAT); end
      begin int r; count_high(cpu_rst, POR_N + 100, r); check("R6 power-on delay", r, LAT + POR_N); end
    join
    tick(5);
    check("R2 normal run", cpu_rst, 0);

    // R7 short glitch on warning comparator
    warn_in = 0; tick(STABLE_N - 1); warn_in = 1;
    count_irq(30, c);
    check("R7 glitch ignored", c, 0);

    // R1 R8 warning, single request, processor keeps running (R2)
    ce_n_in = 4'b1010; rw_n_in = 0;
    warn_in = 0;
    count_low(irq, 40, c);
    check("R1 irq latency", c, LAT + 1);
    check("R1 vector", vec, 8'h2B);
    count_irq(60, c);
    check("R8 single request", c, 0);
    check("R2 no reset in warn", cpu_rst, 0);
    check("R2 ce pass", ce_n_out, 4'b1010);
    check("R2 rw pass", rw_n_out, 0);

    // R8 re-arm after recovery
    warn_in = 1; tick(20);
    warn_in = 0;
    count_irq(40, c);
    check("R8 rearmed request", c, 1);
    warn_in = 1; tick(20);

    // R11 disabled warning
    warn_en = 0; warn_in = 0;
    count_irq(40, c);
    check("R11 no request when disabled", c, 0);
    warn_in = 1; tick(20); warn_en = 1;

    // R9 external reset
    ext_rst = 1; #1;
    check("R9 ext reset same cycle", cpu_rst, 1);
    tick(2); ext_rst = 0; #1;
    check("R9 ext reset release", cpu_rst, 0);

    // R3 minimum level lost
    ce_n_in = 4'b0000; rw_n_in = 0;
    tick(1);
    min_in = 0;
    count_low(cpu_rst, 40, c);
    check("R3 reset latency", c, LAT);
    check("R4 ce forced", ce_n_out, 4'b1111);
    check("R4 rw forced", rw_n_out, 1);
    tick(50);
    check("R3 reset held", cpu_rst, 1);
    warn_in = 0;
    min_in = 1;
    count_high(cpu_rst, POR_N + 100, c);
    check("R6 delay after reset stage", c, LAT + POR_N);
    tick(3);
    check("R6 exit to warn keeps running", cpu_rst, 0);
    warn_in = 1; tick(20);

    // R5 backup level lost, then restored
    bkp_in = 0; warn_in = 0; min_in = 0;
    count_low(bkp_sel, 40, c);
    check("R5 backup latency", c, LAT);
    tick(30);
    check("R5 backup held", bkp_sel, 1);
    bkp_in = 1; min_in = 1; warn_in = 1;
    count_high(cpu_rst, POR_N + 100, c);
    check("R6 delay after backup", c, LAT + POR_N);
    tick(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < WDOG) begin @(posedge clk); cycles++; end
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=<%0d", cycles, WDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule